// File: doc/BRIEF.md
# Host Channel Request Queue with Halt Sequencing

This block manages the transaction requests that the channels of a small multi-channel USB-style host controller post for the bus engine. It keeps two request FIFOs, one for nonperiodic and one for periodic traffic. A round-robin arbiter visits one channel per cycle. On its turn, a channel may add one entry to the FIFO that matches its type. The bus engine takes token entries from the FIFO heads. Periodic entries win over nonperiodic ones, and the engine runs one transaction at a time, marked by a start pulse and a done pulse.

Software controls each channel through an enable bit and a disable bit, written together with a per-channel write strobe. Writing both bits as 1 halts the channel. Its unissued tokens are purged from both FIFOs, and a disable entry is queued on the channel's own arbitration turn once the matching FIFO has a free slot. When that entry reaches the head, it is consumed without any bus activity. It then raises the channel's sticky halted interrupt and clears the channel's enable, so that the channel can be reused. A transaction the channel already has on the bus is never cut short: the interrupt waits until it is done. Writing disable alone only purges the channel's tokens.

Top module: `hc_reqq`

## Requirements
- R1: After reset, every channel enable and halted interrupt is 0. post_ack is 0 and iss_valid is 0.
- R2: The arbiter turn is channel 0 in the first cycle after reset and advances by one channel every cycle, wrapping around. On its turn, a channel that is enabled, not halting, has post_req high, and is not being disabled in that cycle, pushes one token. The token goes to the periodic FIFO when its ch_periodic bit is 1 and to the nonperiodic FIFO otherwise. post_ack for that channel pulses in the following cycle.
- R3: A control write with enable=1 and disable=1 marks the channel as halting. It removes every token of that channel that has not been issued from both FIFOs. The remaining entries keep their order.
- R4: A control write with disable=1 and enable=0 removes the channel's tokens and has no other effect: no interrupt, and the enable bit is unchanged. A write with disable=0 sets the enable bit to the value of the enable field.
- R5: A halting channel's disable entry is pushed only on that channel's own turn, and only when the FIFO of its type is not full. Otherwise the push is retried on later turns. A disable entry at a FIFO head is removed without being offered to the bus, and it sets the channel's halt_irq bit.
- R6: A disable entry for a channel whose transaction is currently on the bus is not consumed before bus_done for that transaction.
- R7: halt_irq stays 1 until an irq_clr pulse for that channel. The channel's post requests are ignored from the halt write until that clear.
- R8: The channel's enable bit goes to 0 in the same cycle that its halt_irq bit rises.
- R9: iss_valid is 1 only when no transaction is in progress and a FIFO head holds a token. The periodic head has priority. iss_ch and iss_periodic describe the offered token. A bus_start pops that token, and each FIFO issues its tokens in arrival order.
- R10: Each FIFO holds QDEPTH (default 4) entries. A post is refused while the target FIFO is full and is accepted on a later turn once space frees up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | NCH | Per-channel control write strobe |
| ctl_ena | input | NCH | Enable field of the control write |
| ctl_dis | input | NCH | Disable field of the control write |
| ch_periodic | input | NCH | Channel type: 1 periodic, 0 nonperiodic |
| irq_clr | input | NCH | Write-1-to-clear strobe for halt_irq |
| post_req | input | NCH | Channel wants to post a token request |
| post_ack | output | NCH | Registered pulse: the post was accepted |
| ch_en | output | NCH | Current channel enable bits |
| halt_irq | output | NCH | Sticky channel-halted interrupt |
| iss_valid | output | 1 | A token is offered to the bus engine |
| iss_periodic | output | 1 | Offered token comes from the periodic FIFO |
| iss_ch | output | log2(NCH) | Channel of the offered token |
| bus_start | input | 1 | Bus engine starts the offered transaction |
| bus_done | input | 1 | The running transaction has completed |

## Verification
The assertions assume that the bus engine raises bus_start only in a cycle where iss_valid is high. They also assume that bus_done comes only while a transaction is running, and never in the same cycle as its start. The bench's engine model reads iss_valid away from the clock edge and starts only then. It counts a programmable number of cycles before pulsing done, and never starts in a done cycle. Post requesters hold post_req until they see post_ack. Because a channel's next turn is at least four cycles away, the late acknowledge can never cause a double post.

// File: rtl/hcq_pkg.sv
package hcq_pkg;
  // Kind of an entry held in a request FIFO
  typedef enum logic {
    K_TOKEN   = 1'b0,
    K_DISABLE = 1'b1
  } req_kind_e;
endpackage

// File: rtl/hcq_fifo.sv
// Request FIFO with same-cycle pop, per-channel token purge (order kept) and push.
module hcq_fifo #(
  parameter int DEPTH = 4,
  parameter int NCH   = 4,
  parameter int CHW   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pop_i,
  input  logic [NCH-1:0]      purge_i,
  input  logic                push_i,
  input  hcq_pkg::req_kind_e  push_kind_i,
  input  logic [CHW-1:0]      push_ch_i,
  output logic                head_vld_o,
  output hcq_pkg::req_kind_e  head_kind_o,
  output logic [CHW-1:0]      head_ch_o,
  output logic                full_o
);
  import hcq_pkg::*;

  logic [DEPTH-1:0] val_q, val_a, val_b;
  req_kind_e        kind_q [DEPTH];
  req_kind_e        kind_a [DEPTH];
  req_kind_e        kind_b [DEPTH];
  logic [CHW-1:0]   ch_q   [DEPTH];
  logic [CHW-1:0]   ch_a   [DEPTH];
  logic [CHW-1:0]   ch_b   [DEPTH];

  always_comb begin
    int wr;
    // pop the head
    for (int i = 0; i < DEPTH; i++) begin
      if (pop_i) begin
        val_a[i]  = (i < DEPTH-1) ? val_q[(i+1)%DEPTH] : 1'b0;
        kind_a[i] = kind_q[(i+1)%DEPTH];
        ch_a[i]   = ch_q[(i+1)%DEPTH];
      end else begin
        val_a[i]  = val_q[i];
        kind_a[i] = kind_q[i];
        ch_a[i]   = ch_q[i];
      end
    end
    // purge tokens of flushed channels, compacting in order
    wr = 0;
    for (int i = 0; i < DEPTH; i++) begin
      val_b[i]  = 1'b0;
      kind_b[i] = K_TOKEN;
      ch_b[i]   = '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (val_a[i] && !(kind_a[i] == K_TOKEN && purge_i[ch_a[i]])) begin
        val_b[wr]  = 1'b1;
        kind_b[wr] = kind_a[i];
        ch_b[wr]   = ch_a[i];
        wr++;
      end
    end
    // append at the tail
    if (push_i && wr < DEPTH) begin
      val_b[wr]  = 1'b1;
      kind_b[wr] = push_kind_i;
      ch_b[wr]   = push_ch_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= K_TOKEN;
        ch_q[i]   <= '0;
      end
    end else begin
      val_q <= val_b;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= kind_b[i];
        ch_q[i]   <= ch_b[i];
      end
    end
  end

  assign head_vld_o  = val_q[0];
  assign head_kind_o = kind_q[0];
  assign head_ch_o   = ch_q[0];
  assign full_o      = val_q[DEPTH-1];

  // R10: the arbiter never pushes into a full FIFO
  a_r10_push_not_full: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);

  // R3: occupied slots stay packed toward the head after purges
  for (genvar g = 1; g < DEPTH; g++) begin : g_pack
    a_r3_compact: assert property (@(posedge clk) disable iff (rst)
      val_q[g] |-> val_q[g-1]);
  end
endmodule

// File: rtl/hcq_chan.sv
// Per-channel enable / halt / interrupt state.
module hcq_chan (
  input  logic clk,
  input  logic rst,
  input  logic we_i,
  input  logic ena_i,
  input  logic dis_i,
  input  logic irq_clr_i,
  input  logic dis_queued_i,
  input  logic halt_done_i,
  output logic en_o,
  output logic halting_o,
  output logic pend_o,
  output logic irq_o
);
  logic en_q, halting_q, pend_q, irq_q;
  logic halt_wr;

  assign halt_wr = we_i && ena_i && dis_i && !halting_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      halting_q <= 1'b0;
      pend_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (we_i && !dis_i) en_q <= ena_i;
      if (halt_done_i)    en_q <= 1'b0;
      if (halt_wr) begin
        halting_q <= 1'b1;
        pend_q    <= 1'b1;
      end
      if (dis_queued_i) pend_q <= 1'b0;
      if (halt_done_i) irq_q <= 1'b1;
      else if (irq_clr_i && irq_q) begin
        irq_q     <= 1'b0;
        halting_q <= 1'b0;
      end
    end
  end

  assign en_o      = en_q;
  assign halting_o = halting_q;
  assign pend_o    = pend_q;
  assign irq_o     = irq_q;

  // R7: an interrupt only exists for a halting channel
  a_r7_irq_implies_halting: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> halting_q);
  // R8: enable is down when the interrupt rises
  a_r8_en_off_on_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> !en_q);
  // R5: a disable still to be queued belongs to a halting, unfinished channel
  a_r5_pend_in_halt: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (halting_q && !irq_q));
endmodule

// File: rtl/hc_reqq.sv
module hc_reqq #(
  parameter int NCH    = 4,
  parameter int QDEPTH = 4,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ctl_we,
  input  logic [NCH-1:0] ctl_ena,
  input  logic [NCH-1:0] ctl_dis,
  input  logic [NCH-1:0] ch_periodic,
  input  logic [NCH-1:0] irq_clr,
  input  logic [NCH-1:0] post_req,
  output logic [NCH-1:0] post_ack,
  output logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] halt_irq,
  output logic           iss_valid,
  output logic           iss_periodic,
  output logic [CHW-1:0] iss_ch,
  input  logic           bus_start,
  input  logic           bus_done
);
  import hcq_pkg::*;

  logic [CHW-1:0] turn_q;
  logic           busy_q;
  logic [CHW-1:0] busy_ch_q;
  logic [NCH-1:0] ack_q, ack_d;

  logic [1:0]     hvld, full, pop, push, dis_take, tok;
  req_kind_e      hkind [2];
  logic [CHW-1:0] hch   [2];
  req_kind_e      push_kind;

  logic [NCH-1:0] en, halting, pend, irq, dis_queued, halt_done, purge;
  logic           tq, want_dis, want_tok, start;

  assign purge = ctl_we & ctl_dis;

  // Two FIFOs: index 0 nonperiodic, index 1 periodic
  for (genvar q = 0; q < 2; q++) begin : g_q
    hcq_fifo #(.DEPTH(QDEPTH), .NCH(NCH), .CHW(CHW)) u_fifo (
      .clk(clk), .rst(rst),
      .pop_i(pop[q]), .purge_i(purge),
      .push_i(push[q]), .push_kind_i(push_kind), .push_ch_i(turn_q),
      .head_vld_o(hvld[q]), .head_kind_o(hkind[q]), .head_ch_o(hch[q]),
      .full_o(full[q])
    );
    assign tok[q]      = hvld[q] && hkind[q] == K_TOKEN;
    assign dis_take[q] = hvld[q] && hkind[q] == K_DISABLE &&
                         !(busy_q && busy_ch_q == hch[q]);
  end

  // Issue side
  assign iss_valid    = !busy_q && (tok[1] || tok[0]);
  assign iss_periodic = tok[1];
  assign iss_ch       = tok[1] ? hch[1] : hch[0];
  assign start        = bus_start && iss_valid;
  assign pop[1]       = dis_take[1] || (start && iss_periodic);
  assign pop[0]       = dis_take[0] || (start && !iss_periodic);

  // Arbitration on the current turn
  assign tq        = ch_periodic[turn_q];
  assign want_dis  = pend[turn_q] && !full[tq];
  assign want_tok  = post_req[turn_q] && en[turn_q] && !halting[turn_q] &&
                     !purge[turn_q] && !full[tq];
  assign push[1]   = (want_dis || want_tok) && tq;
  assign push[0]   = (want_dis || want_tok) && !tq;
  assign push_kind = want_dis ? K_DISABLE : K_TOKEN;

  always_comb begin
    dis_queued = '0;
    ack_d      = '0;
    if (want_dis)      dis_queued[turn_q] = 1'b1;
    else if (want_tok) ack_d[turn_q]      = 1'b1;
    for (int c = 0; c < NCH; c++)
      halt_done[c] = (dis_take[0] && hch[0] == CHW'(c)) ||
                     (dis_take[1] && hch[1] == CHW'(c));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hcq_chan u_chan (
      .clk(clk), .rst(rst),
      .we_i(ctl_we[c]), .ena_i(ctl_ena[c]), .dis_i(ctl_dis[c]),
      .irq_clr_i(irq_clr[c]), .dis_queued_i(dis_queued[c]),
      .halt_done_i(halt_done[c]),
      .en_o(en[c]), .halting_o(halting[c]), .pend_o(pend[c]), .irq_o(irq[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      turn_q    <= '0;
      busy_q    <= 1'b0;
      busy_ch_q <= '0;
      ack_q     <= '0;
    end else begin
      turn_q <= (turn_q == CHW'(NCH-1)) ? '0 : turn_q + 1'b1;
      ack_q  <= ack_d;
      if (bus_done) busy_q <= 1'b0;
      if (start) begin
        busy_q    <= 1'b1;
        busy_ch_q <= iss_ch;
      end
    end
  end

  assign post_ack = ack_q;
  assign ch_en    = en;
  assign halt_irq = irq;

  // R9: the engine only starts what is offered
  a_r9_start_offered: assert property (@(posedge clk) disable iff (rst)
    bus_start |-> iss_valid);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R6: no halt completes while that channel's transaction is on the bus
    a_r6_no_halt_in_own_txn: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[c]) |-> !($past(busy_q) && $past(busy_ch_q) == CHW'(c)));
    // R2: an accepted post came from an enabled channel
    a_r2_ack_when_enabled: assert property (@(posedge clk) disable iff (rst)
      post_ack[c] |-> $past(en[c]));
  end
endmodule

// File: tb/sim_hc_reqq.sv
module sim_hc_reqq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ctl_we = '0, ctl_ena = '0, ctl_dis = '0, irq_clr = '0;
  logic [3:0] ch_periodic = 4'b1100;
  logic [3:0] post_req;
  logic [3:0] post_ack, ch_en, halt_irq;
  logic       iss_valid, iss_periodic;
  logic [1:0] iss_ch;
  logic       bus_start = 1'b0, bus_done = 1'b0;

  always #2.5 clk = ~clk;

  hc_reqq #(.NCH(4), .QDEPTH(4)) u0 (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_ena(ctl_ena), .ctl_dis(ctl_dis),
    .ch_periodic(ch_periodic), .irq_clr(irq_clr), .post_req(post_req),
    .post_ack(post_ack), .ch_en(ch_en), .halt_irq(halt_irq),
    .iss_valid(iss_valid), .iss_periodic(iss_periodic), .iss_ch(iss_ch),
    .bus_start(bus_start), .bus_done(bus_done)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- stimulus agents ----------------
  int want [4] = '{0, 0, 0, 0};
  int issued [4] = '{0, 0, 0, 0};
  int log_q[$];
  bit eng_go = 0, eng_busy = 0;
  int eng_len = 2, eng_cnt = 0;

  always_comb for (int c = 0; c < 4; c++) post_req[c] = want[c] > 0;

  always @(negedge clk) begin
    bus_start = 1'b0;
    bus_done  = 1'b0;
    if (!rst) begin
      for (int c = 0; c < 4; c++)
        if (post_ack[c] && want[c] > 0) want[c]--;
      if (eng_busy) begin
        eng_cnt--;
        if (eng_cnt == 0) begin
          bus_done = 1'b1;
          eng_busy = 0;
        end
      end else if (eng_go && iss_valid) begin
        bus_start = 1'b1;
        eng_busy  = 1;
        eng_cnt   = eng_len;
        issued[iss_ch]++;
        log_q.push_back(int'(iss_ch));
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  int  mq0[$], mq1[$];          // entry = kind*16 + channel, kind 1 = disable
  bit  m_en[4], m_halt[4], m_pend[4], m_irq[4], m_ack[4];
  bit  m_busy;
  int  m_bch, m_turn;
  bit  mt0, mt1, md0, md1, mv, mp;
  int  mc;

  function automatic void m_eval();
    mt0 = mq0.size() > 0 && mq0[0] < 16;
    mt1 = mq1.size() > 0 && mq1[0] < 16;
    md0 = mq0.size() > 0 && mq0[0] >= 16 && !(m_busy && m_bch == mq0[0] % 16);
    md1 = mq1.size() > 0 && mq1[0] >= 16 && !(m_busy && m_bch == mq1[0] % 16);
    mv  = !m_busy && (mt0 || mt1);
    mp  = mt1;
    mc  = mt1 ? mq1[0] : (mt0 ? mq0[0] : 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq0.delete(); mq1.delete();
      for (int c = 0; c < 4; c++) begin
        m_en[c] = 0; m_halt[c] = 0; m_pend[c] = 0; m_irq[c] = 0; m_ack[c] = 0;
      end
      m_busy = 0; m_bch = 0; m_turn = 0;
    end else begin
      int c, tq, h0, h1, tmp[$];
      bit free, wdis, wtok, st;
      m_eval();
      h0 = md0 ? mq0[0] % 16 : -1;
      h1 = md1 ? mq1[0] % 16 : -1;
      st = bus_start && mv;
      c  = m_turn;
      tq = int'(ch_periodic[c]);
      free = (tq == 1) ? (mq1.size() < 4) : (mq0.size() < 4);
      wdis = m_pend[c] && free;
      wtok = post_req[c] && m_en[c] && !m_halt[c] && !(ctl_we[c] && ctl_dis[c]) && free;
      if (md0 || (st && !mp)) void'(mq0.pop_front());
      if (md1 || (st && mp))  void'(mq1.pop_front());
      tmp = {};
      foreach (mq0[i]) if (!(mq0[i] < 16 && ctl_we[mq0[i]] && ctl_dis[mq0[i]])) tmp.push_back(mq0[i]);
      mq0 = tmp;
      tmp = {};
      foreach (mq1[i]) if (!(mq1[i] < 16 && ctl_we[mq1[i]] && ctl_dis[mq1[i]])) tmp.push_back(mq1[i]);
      mq1 = tmp;
      if (wdis || wtok) begin
        if (tq == 1) mq1.push_back((wdis ? 16 : 0) + c);
        else         mq0.push_back((wdis ? 16 : 0) + c);
      end
      for (int k = 0; k < 4; k++) begin
        bit done;
        done = (h0 == k) || (h1 == k);
        if (ctl_we[k] && !ctl_dis[k]) m_en[k] = ctl_ena[k];
        if (done) m_en[k] = 0;
        if (ctl_we[k] && ctl_ena[k] && ctl_dis[k] && !m_halt[k]) begin
          m_halt[k] = 1; m_pend[k] = 1;
        end
        if (wdis && c == k) m_pend[k] = 0;
        if (done) m_irq[k] = 1;
        else if (irq_clr[k] && m_irq[k]) begin m_irq[k] = 0; m_halt[k] = 0; end
        m_ack[k] = (wtok && !wdis && c == k);
      end
      if (bus_done) m_busy = 0;
      if (st) begin m_busy = 1; m_bch = mc % 16; end
      m_turn = (m_turn + 1) % 4;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      m_eval();
      chk("R9 iss_valid", int'(iss_valid), int'(mv));
      if (mv) begin
        chk("R9 iss_ch", int'(iss_ch), mc % 16);
        chk("R9 iss_periodic", int'(iss_periodic), int'(mp));
      end
      for (int c = 0; c < 4; c++) begin
        chk("R2 post_ack", int'(post_ack[c]), int'(m_ack[c]));
        chk("R7 halt_irq", int'(halt_irq[c]), int'(m_irq[c]));
        chk("R8 ch_en", int'(ch_en[c]), int'(m_en[c]));
      end
    end
  end

  // ---------------- directed scenario ----------------
  task automatic ctl(input logic [3:0] we, input logic [3:0] ena, input logic [3:0] dis);
    ctl_we = we; ctl_ena = ena; ctl_dis = dis;
    @(negedge clk);
    ctl_we = '0; ctl_ena = '0; ctl_dis = '0;
  endtask

  task automatic clr_irq(input logic [3:0] m);
    irq_clr = m;
    @(negedge clk);
    irq_clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 halt_irq", int'(halt_irq), 0);
    chk("R1 ch_en", int'(ch_en), 0);
    chk("R1 iss_valid", int'(iss_valid), 0);
    chk("R1 post_ack", int'(post_ack), 0);

    // R4 enable write, R2 posting through both FIFOs
    ctl(4'hF, 4'hF, 4'h0);
    chk("R4 enable write", int'(ch_en), 15);
    eng_go = 1; eng_len = 2;
    for (int c = 0; c < 4; c++) want[c] = 2;
    repeat (80) @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      chk("R2 issued per channel", issued[c], 2);
      chk("R2 posts accepted", want[c], 0);
    end

    // R10 full FIFO refuses posts, then retries
    eng_go = 0;
    want[0] = 6;
    repeat (40) @(negedge clk);
    chk("R10 refused while full", want[0], 2);
    chk("R9 head offered valid", int'(iss_valid), 1);
    chk("R9 head offered ch", int'(iss_ch), 0);
    chk("R9 head offered np", int'(iss_periodic), 0);
    eng_go = 1; eng_len = 1;
    repeat (60) @(negedge clk);
    chk("R10 retried later", issued[0], 8);

    // R3 halt purges ch0 tokens, keeps ch1 order
    eng_go = 0;
    want[0] = 2; want[1] = 2;
    repeat (30) @(negedge clk);
    ctl(4'h1, 4'h1, 4'h1);
    log_q.delete();
    eng_go = 1; eng_len = 2;
    repeat (40) @(negedge clk);
    chk("R3 remaining issued", log_q.size(), 2);
    chk("R3 first remaining", (log_q.size() > 0) ? log_q[0] : -1, 1);
    chk("R3 second remaining", (log_q.size() > 1) ? log_q[1] : -1, 1);
    chk("R5 halt irq raised", int'(halt_irq[0]), 1);
    chk("R8 enable cleared", int'(ch_en[0]), 0);
    repeat (10) @(negedge clk);
    chk("R7 irq sticky", int'(halt_irq[0]), 1);
    want[0] = 1;
    repeat (20) @(negedge clk);
    chk("R7 post ignored while halted", want[0], 1);
    clr_irq(4'h1);
    chk("R7 irq cleared", int'(halt_irq[0]), 0);
    ctl(4'h1, 4'h1, 4'h0);
    repeat (20) @(negedge clk);
    chk("R7 posting resumes", want[0], 0);

    // R6 halt waits for the channel's running transaction
    eng_len = 30;
    want[3] = 1;
    for (int i = 0; i < 50 && issued[3] < 3; i++) @(negedge clk);
    ctl(4'h8, 4'h8, 4'h8);
    repeat (10) @(negedge clk);
    chk("R6 no irq during own txn", int'(halt_irq[3]), 0);
    repeat (40) @(negedge clk);
    chk("R6 irq after done", int'(halt_irq[3]), 1);
    chk("R8 enable cleared ch3", int'(ch_en[3]), 0);
    clr_irq(4'h8);

    // R4 flush-only write
    eng_go = 0; eng_len = 2;
    want[1] = 2;
    repeat (20) @(negedge clk);
    ctl(4'h2, 4'h0, 4'h2);
    repeat (20) @(negedge clk);
    chk("R4 no irq on flush", int'(halt_irq[1]), 0);
    chk("R4 enable kept", int'(ch_en[1]), 1);
    log_q.delete();
    eng_go = 1;
    repeat (20) @(negedge clk);
    chk("R4 tokens flushed", log_q.size(), 0);
    want[1] = 1;
    repeat (20) @(negedge clk);
    chk("R4 channel still posts", log_q.size(), 1);

    // R5 disable waits for FIFO space; R9 periodic priority
    eng_go = 0;
    ctl(4'h8, 4'h8, 4'h0);
    want[3] = 4; want[1] = 1;
    repeat (30) @(negedge clk);
    ctl(4'h4, 4'h4, 4'h4);
    repeat (30) @(negedge clk);
    chk("R5 no space no disable", int'(halt_irq[2]), 0);
    log_q.delete();
    eng_go = 1;
    repeat (80) @(negedge clk);
    chk("R9 issue count", log_q.size(), 5);
    chk("R9 periodic first", (log_q.size() > 0) ? log_q[0] : -1, 3);
    chk("R9 nonperiodic last", (log_q.size() > 4) ? log_q[4] : -1, 1);
    chk("R5 disable after retry", int'(halt_irq[2]), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 30000 && !finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 30000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule